// File: doc/BRIEF.md
# ADC Result Formatting Register Interface

This block sits between a 10-bit conversion engine and a CPU register bus. Each time the engine signals a finished conversion, the block packs the result into an 8-bit high data register and an 8-bit low data register. Four packing formats are available. The CPU controls single-shot and back-to-back conversion runs through a control register and watches a completion flag.

A read guard keeps the two data registers consistent with each other. Reading the high register arms the guard. Until the low register is read, every arriving result is dropped and both registers keep their contents. The block drives a run request to the engine and accepts a one-cycle result strobe together with the 10-bit value.

Register map, one 8-bit register per bus address:
- address 0 is control/status: bit 7 is the completion flag (read-only), bit 1 selects continuous runs, bit 0 enables conversion.
- address 1 is the data high register.
- address 2 is the data low register.
- address 3 is the format register: bits 1:0 hold the format code.

Top module: `adc_result_if`

## Requirements
- R1: After a synchronous active-high reset, all four registers read 0x00 and `conv_run` is low.
- R2: Format code 00 (left-justified) stores result bits 9..2 in data high, and result bits 1..0 in data low bits 7..6, with zeros below them.
- R3: Format code 01 (right-justified) stores result bits 9..8 in data high bits 1..0, with zeros above them, and result bits 7..0 in data low.
- R4: Format code 10 (signed left-justified) packs the result as format 00 does, except that data high bit 7 holds the inverse of result bit 9.
- R5: Format code 11 (truncation) stores result bits 9..2 in data low, and data high reads 0x00.
- R6: While control bits 1 and 0 are both set, each accepted result overwrites both data registers, whether or not the previous result was read, and `conv_run` stays high until enable is cleared.
- R7: With bit 0 set and bit 1 clear, the first stored result clears enable, so `conv_run` falls.
- R8: The completion flag (address 0 bit 7) sets when a result is stored, and stays set across later stored results.
- R9: The flag clears on a write to address 0, or on a read of address 1 or address 2. If a result is stored in the same cycle, the set wins.
- R10: A read of address 1 arms the read guard. While it is armed, arriving results are dropped and both data registers hold. The next read of address 2 releases it.
- R11: A result strobe arriving while enable is clear changes neither data register nor the flag.
- R12: Register bits not listed in the map read as zero. A write of 0xFF to address 3 reads back as 0x03, and a write of 0xFF to address 0 reads back as 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| conv_valid | input | 1 | One-cycle strobe from the converter: a result is ready |
| conv_data | input | 10 | Conversion result |
| conv_run | output | 1 | Request to the converter to keep converting |

## Verification
Most faults in this block show up on the bus one cycle after the triggering edge.

A wrongly held guard bit makes a fresh result fail to appear after the low register has been read. A guard bit that is wrongly clear lets a dropped result overwrite the high/low pair between two reads.

A stuck enable or continuous bit appears on `conv_run` right after the first stored result. A flag state error appears on address 0 bit 7 at the next read of that register. A wrong format code shows up in the very first stored result as misplaced bits.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    typedef enum logic [1:0] {
        FMT_LEFT   = 2'b00,
        FMT_RIGHT  = 2'b01,
        FMT_SIGNED = 2'b10,
        FMT_TRUNC  = 2'b11
    } fmt_mode_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_LO   = 2'd2;
    localparam logic [1:0] ADDR_FMT  = 2'd3;

    typedef struct packed {
        logic      enable;
        logic      cont;
        logic      flag;
        logic      guard;
        fmt_mode_e mode;
    } ctl_state_t;

endpackage

// File: rtl/adc_fmt_pack.sv
module adc_fmt_pack
    import adc_fmt_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic [RES_W-1:0]  res,
    input  fmt_mode_e         mode,
    output logic [DATA_W-1:0] hi,
    output logic [DATA_W-1:0] lo
);
    localparam int XTRA = RES_W - DATA_W;
    localparam int PAD  = 2 * DATA_W - RES_W;

    logic [DATA_W-1:0] top_bits;
    logic [DATA_W-1:0] left_lo;
    logic [DATA_W-1:0] right_hi;

    assign top_bits = res[RES_W-1 -: DATA_W];
    assign left_lo  = {res[XTRA-1:0], {(DATA_W-XTRA){1'b0}}};
    assign right_hi = {{PAD{1'b0}}, res[RES_W-1:DATA_W]};

    always_comb begin
        hi = '0;
        lo = '0;
        unique case (mode)
            FMT_LEFT: begin
                hi = top_bits;
                lo = left_lo;
            end
            FMT_RIGHT: begin
                hi = right_hi;
                lo = res[DATA_W-1:0];
            end
            FMT_SIGNED: begin
                hi = {~top_bits[DATA_W-1], top_bits[DATA_W-2:0]};
                lo = left_lo;
            end
            FMT_TRUNC: begin
                hi = '0;
                lo = top_bits;
            end
            default: begin
                hi = '0;
                lo = '0;
            end
        endcase
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_fmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_ctrl,
    input  logic      wr_fmt,
    input  logic [1:0] wbits,
    input  logic      rd_hi,
    input  logic      rd_lo,
    input  logic      conv_valid,
    output logic      store,
    output logic      enable,
    output logic      cont,
    output logic      flag,
    output logic      guard,
    output fmt_mode_e mode
);
    ctl_state_t st_d, st_q;

    always_comb begin
        store = conv_valid && st_q.enable && !st_q.guard && !rd_hi;
        st_d  = st_q;
        if (store && !st_q.cont) st_d.enable = 1'b0;
        if (wr_ctrl) begin
            st_d.enable = wbits[0];
            st_d.cont   = wbits[1];
        end
        if (wr_ctrl || rd_hi || rd_lo) st_d.flag = 1'b0;
        if (store) st_d.flag = 1'b1;
        if (rd_hi)      st_d.guard = 1'b1;
        else if (rd_lo) st_d.guard = 1'b0;
        if (wr_fmt) st_d.mode = fmt_mode_e'(wbits);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{enable: 1'b0, cont: 1'b0, flag: 1'b0, guard: 1'b0, mode: FMT_LEFT};
        else     st_q <= st_d;
    end

    assign enable = st_q.enable;
    assign cont   = st_q.cont;
    assign flag   = st_q.flag;
    assign guard  = st_q.guard;
    assign mode   = st_q.mode;

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        store |=> flag);

    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl || rd_hi || rd_lo) && !store |=> !flag);

    // R7
    single_stop_chk: assert property (@(posedge clk) disable iff (rst)
        store && !cont && !wr_ctrl |=> !enable);
endmodule

// File: rtl/adc_result_if.sv
module adc_result_if
    import adc_fmt_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              conv_valid,
    input  logic [RES_W-1:0]  conv_data,
    output logic              conv_run
);
    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } data_regs_t;

    data_regs_t dr_d, dr_q;

    logic              wr_ctrl, wr_fmt, rd_hi, rd_lo;
    logic              store, enable, cont, flag, guard;
    fmt_mode_e         mode;
    logic [DATA_W-1:0] fmt_hi, fmt_lo;
    logic              unused_wbits;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_fmt  = bus_wr && (bus_addr == ADDR_FMT);
    assign rd_hi   = bus_rd && (bus_addr == ADDR_HI);
    assign rd_lo   = bus_rd && (bus_addr == ADDR_LO);
    assign unused_wbits = ^bus_wdata[DATA_W-1:2];

    adc_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wr_fmt     (wr_fmt),
        .wbits      (bus_wdata[1:0]),
        .rd_hi      (rd_hi),
        .rd_lo      (rd_lo),
        .conv_valid (conv_valid),
        .store      (store),
        .enable     (enable),
        .cont       (cont),
        .flag       (flag),
        .guard      (guard),
        .mode       (mode)
    );

    adc_fmt_pack #(.RES_W(RES_W), .DATA_W(DATA_W)) u_pack (
        .res  (conv_data),
        .mode (mode),
        .hi   (fmt_hi),
        .lo   (fmt_lo)
    );

    always_comb begin
        dr_d = dr_q;
        if (store) begin
            dr_d.hi = fmt_hi;
            dr_d.lo = fmt_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dr_q <= '0;
        else     dr_q <= dr_d;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = {flag, {(DATA_W-3){1'b0}}, cont, enable};
            ADDR_HI:   bus_rdata = dr_q.hi;
            ADDR_LO:   bus_rdata = dr_q.lo;
            default:   bus_rdata = {{(DATA_W-2){1'b0}}, mode};
        endcase
    end

    assign conv_run = enable;

    // R10
    guard_hold_chk: assert property (@(posedge clk) disable iff (rst)
        guard |=> $stable(dr_q));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_run |=> $stable(dr_q));

    // R4
    signed_msb_chk: assert property (@(posedge clk) disable iff (rst)
        store && mode == FMT_SIGNED |=> dr_q.hi[DATA_W-1] != $past(conv_data[RES_W-1]));

    // R5
    trunc_hi_chk: assert property (@(posedge clk) disable iff (rst)
        store && mode == FMT_TRUNC |=> dr_q.hi == '0);
endmodule

// File: tb/tb_adc_result_if.sv
module tb_adc_result_if;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       conv_valid = 1'b0;
    logic [9:0] conv_data = '0;
    logic       conv_run;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    adc_result_if dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_valid(conv_valid), .conv_data(conv_data), .conv_run(conv_run)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic push(input logic [9:0] r);
        conv_data = r; conv_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic expect_pair(input string req, input logic [7:0] h, input logic [7:0] l);
        logic [7:0] v;
        peek(2'd1, v); check(req, v, h);
        peek(2'd2, v); check(req, v, l);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            peek(a[1:0], v); check("R1", v, 8'h00);
        end
        check("R1 conv_run", {7'b0, conv_run}, 8'h00);
    endtask

    task automatic t_format(input logic [1:0] m, input string req,
                            input logic [7:0] h, input logic [7:0] l);
        wr(2'd3, {6'b0, m});
        wr(2'd0, 8'h03);
        push(10'h2D6);
        expect_pair(req, h, l);
    endtask

    task automatic t_map;
        logic [7:0] v;
        wr(2'd3, 8'hFF);
        peek(2'd3, v); check("R12 fmt", v, 8'h03);
        wr(2'd0, 8'h03);
        push(10'h100);
        peek(2'd0, v); check("R12 R8 ctrl flag", v, 8'h83);
        wr(2'd0, 8'hFF);
        peek(2'd0, v); check("R12 R9 ctrl wr", v, 8'h03);
    endtask

    task automatic t_continuous;
        logic [7:0] v;
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h03);
        push(10'h0AB);
        peek(2'd0, v); check("R8 first", v, 8'h83);
        push(10'h3CD);
        expect_pair("R6 overwrite", 8'h03, 8'hCD);
        peek(2'd0, v); check("R8 stays", v, 8'h83);
        check("R6 run", {7'b0, conv_run}, 8'h01);
        rd(2'd2, v); check("R9 read lo value", v, 8'hCD);
        peek(2'd0, v); check("R9 lo clears", v, 8'h03);
    endtask

    task automatic t_guard;
        logic [7:0] v;
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h03);
        push(10'h3FF);
        expect_pair("R2 all ones", 8'hFF, 8'hC0);
        rd(2'd1, v); check("R10 hi read", v, 8'hFF);
        peek(2'd0, v); check("R9 hi clears", v, 8'h03);
        push(10'h001);
        expect_pair("R10 dropped", 8'hFF, 8'hC0);
        peek(2'd0, v); check("R10 no flag", v, 8'h03);
        rd(2'd2, v); check("R10 lo read", v, 8'hC0);
        push(10'h001);
        expect_pair("R10 released", 8'h00, 8'h40);
    endtask

    task automatic t_single;
        logic [7:0] v;
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h01);
        check("R7 run on", {7'b0, conv_run}, 8'h01);
        push(10'h155);
        expect_pair("R7 stored", 8'h01, 8'h55);
        check("R7 run off", {7'b0, conv_run}, 8'h00);
        peek(2'd0, v); check("R7 ctrl", v, 8'h80);
        push(10'h2AA);
        expect_pair("R11 after single", 8'h01, 8'h55);
    endtask

    task automatic t_disabled;
        logic [7:0] v;
        wr(2'd0, 8'h00);
        push(10'h3A5);
        expect_pair("R11 disabled", 8'h01, 8'h55);
        peek(2'd0, v); check("R11 flag", v, 8'h00);
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_format(2'b00, "R2 left",   8'hB5, 8'h80);
        t_format(2'b01, "R3 right",  8'h02, 8'hD6);
        t_format(2'b10, "R4 signed", 8'h35, 8'h80);
        t_format(2'b11, "R5 trunc",  8'h00, 8'hB5);
        t_map();
        t_continuous();
        t_guard();
        t_single();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule